// File: doc/BRIEF.md
# Single-Level Translation Refill Engine

This block services translation-buffer misses. A miss request names a virtual page and whether the access is a write. The engine reads the matching 32-bit entry from a single-level table in memory. The table's physical start address sits in a root register. If the entry is not resident, the engine raises a page fault and does not refill the buffer. Otherwise it keeps the usage bits in memory current, writing the entry back only when a bit has to change, and then presents the translation on a fill output for one cycle.

A process switch needs only a new root address, which is loaded while the engine is idle. The engine handles one miss at a time. Memory is reached through a request/acknowledge handshake whose latency may be any number of cycles.

Top module: `ptw_top`

## Requirements
- R1: After reset the engine is idle: `busy`, `mem_req`, `fill_valid` and `fault_valid` are low.
- R2: A miss is accepted when `miss_valid` is high and `busy` is low. `busy` goes high on the next cycle and stays high until the cycle in which `fill_valid` or `fault_valid` is high. Miss requests made while `busy` is high are ignored.
- R3: The read of the entry uses byte address `root + vpn*4` (32-bit arithmetic, `vpn` zero-extended), with `mem_we` low.
- R4: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values.
- R5: Entry layout: [31:12] frame number, [5] read permit, [4] write permit, [3] execute permit, [2] valid, [1] referenced, [0] modified. If bit 2 is 0, `fault_valid` pulses for one cycle with `fault_vpn` equal to the missing page. There is no fill and no write.
- R6: For a valid entry where bit 1 is 0, or where the access is a write and bit 0 is 0, the entry is written back to the same address before the fill. The written word has bit 1 set, bit 0 also set for writes, and every other bit unchanged.
- R7: If every bit that needs setting is already set, no memory write is issued.
- R8: A fill is a one-cycle `fill_valid` pulse. It carries `fill_vpn`, `fill_pfn` = entry[31:12], `fill_perm` = entry[5:3], and `fill_dirty`, which is the modified bit as it stands after the update.
- R9: `root_we` loads `root_wdata` only while `busy` is low. Writes made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_we | input | 1 | Load table root register |
| root_wdata | input | 32 | New table root address |
| miss_valid | input | 1 | Miss request |
| miss_vpn | input | 20 | Missing virtual page number |
| miss_write | input | 1 | Missing access is a write |
| busy | output | 1 | A miss is being resolved |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with ack on reads |
| fill_valid | output | 1 | Translation fill pulse |
| fill_vpn | output | 20 | Filled virtual page |
| fill_pfn | output | 20 | Filled frame number |
| fill_perm | output | 3 | Read, write, execute permits |
| fill_dirty | output | 1 | Modified bit after update |
| fault_valid | output | 1 | Page fault pulse |
| fault_vpn | output | 20 | Faulting virtual page |

## Verification
The assertions check the handshake on every cycle. They cover address and data holding steady while a request waits, fill and fault never occurring together, each result ending the busy period, and the read address following from the root and page. Only the bench scenarios can show the rest. That includes whether a write-back happens, the exact updated word, the ignoring of misses and root loads during a walk, and the chosen fields reaching the fill output across different memory latencies.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    parameter int unsigned AW   = 32;
    parameter int unsigned VPNW = 20;
    parameter int unsigned PTEW = 32;

    localparam int unsigned PFN_LSB = 12;
    localparam int unsigned PFNW    = PTEW - PFN_LSB;
    localparam int unsigned B_VAL   = 2;
    localparam int unsigned B_REF   = 1;
    localparam int unsigned B_MOD   = 0;

    typedef enum logic [2:0] {
        ST_IDLE, ST_READ, ST_CHECK, ST_WRITE, ST_FILL, ST_FAULT
    } walk_state_e;
endpackage

// File: rtl/ptw_root_reg.sv
module ptw_root_reg
    import ptw_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] root
);
    logic [AW-1:0] root_d, root_q;

    always_comb begin
        root_d = root_q;
        if (wr_en && !busy) root_d = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) root_q <= '0;
        else        root_q <= root_d;
    end

    assign root = root_q;

    a_r9_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(root_q));
endmodule

// File: rtl/ptw_pte_update.sv
module ptw_pte_update
    import ptw_pkg::*;
(
    input  logic [PTEW-1:0] pte_in,
    input  logic            is_write,
    output logic [PTEW-1:0] pte_out,
    output logic            need_wb
);
    always_comb begin
        pte_out        = pte_in;
        pte_out[B_REF] = 1'b1;
        if (is_write) pte_out[B_MOD] = 1'b1;
        need_wb = pte_out != pte_in;
    end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            root_we,
    input  logic [AW-1:0]   root_wdata,
    input  logic            miss_valid,
    input  logic [VPNW-1:0] miss_vpn,
    input  logic            miss_write,
    output logic            busy,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [PTEW-1:0] mem_wdata,
    input  logic            mem_ack,
    input  logic [PTEW-1:0] mem_rdata,
    output logic            fill_valid,
    output logic [VPNW-1:0] fill_vpn,
    output logic [PFNW-1:0] fill_pfn,
    output logic [2:0]      fill_perm,
    output logic            fill_dirty,
    output logic            fault_valid,
    output logic [VPNW-1:0] fault_vpn
);
    typedef struct packed {
        walk_state_e     st;
        logic [VPNW-1:0] vpn;
        logic            wr;
        logic [AW-1:0]   addr;
        logic [PTEW-1:0] pte;
    } walk_s;

    walk_s s_d, s_q;
    logic [AW-1:0]   root;
    logic [PTEW-1:0] pte_upd;
    logic            need_wb;

    assign busy = s_q.st != ST_IDLE;

    ptw_root_reg u_root (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .wr_en(root_we), .wr_data(root_wdata), .root(root)
    );

    ptw_pte_update u_upd (
        .pte_in(s_q.pte), .is_write(s_q.wr),
        .pte_out(pte_upd), .need_wb(need_wb)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: if (miss_valid) begin
                s_d.st   = ST_READ;
                s_d.vpn  = miss_vpn;
                s_d.wr   = miss_write;
                s_d.addr = root + (AW'(miss_vpn) << 2);
            end
            ST_READ: if (mem_ack) begin
                s_d.pte = mem_rdata;
                s_d.st  = ST_CHECK;
            end
            ST_CHECK: begin
                if (!s_q.pte[B_VAL]) s_d.st = ST_FAULT;
                else if (need_wb)    s_d.st = ST_WRITE;
                else                 s_d.st = ST_FILL;
                s_d.pte = pte_upd;
            end
            ST_WRITE: if (mem_ack) s_d.st = ST_FILL;
            ST_FILL:  s_d.st = ST_IDLE;
            ST_FAULT: s_d.st = ST_IDLE;
            default:  s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st   <= ST_IDLE;
            s_q.vpn  <= '0;
            s_q.wr   <= 1'b0;
            s_q.addr <= '0;
            s_q.pte  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_req     = (s_q.st == ST_READ) || (s_q.st == ST_WRITE);
    assign mem_we      = s_q.st == ST_WRITE;
    assign mem_addr    = s_q.addr;
    assign mem_wdata   = s_q.pte;
    assign fill_valid  = s_q.st == ST_FILL;
    assign fill_vpn    = s_q.vpn;
    assign fill_pfn    = s_q.pte[PTEW-1:PFN_LSB];
    assign fill_perm   = s_q.pte[5:3];
    assign fill_dirty  = s_q.pte[B_MOD];
    assign fault_valid = s_q.st == ST_FAULT;
    assign fault_vpn   = s_q.vpn;

    a_r4_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
    a_r8_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_valid && fault_valid));
    a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid || fault_valid |=> !busy);
    a_r3_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && miss_valid |=> mem_addr == $past(root) + ({12'd0, $past(miss_vpn)} << 2));
    a_r5_no_write_fault: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> $past(!mem_we));
endmodule

// File: tb/test_ptw_top.sv
module test_ptw_top;
    logic        clk = 0, rst_n = 0;
    logic        root_we = 0, miss_valid = 0, miss_write = 0, mem_ack = 0;
    logic [31:0] root_wdata = 0, mem_rdata = 0;
    logic [19:0] miss_vpn = 0;
    logic        busy, mem_req, mem_we, fill_valid, fill_dirty, fault_valid;
    logic [31:0] mem_addr, mem_wdata;
    logic [19:0] fill_vpn, fill_pfn, fault_vpn;
    logic [2:0]  fill_perm;
    int errors = 0, checks = 0;
    int writes_seen;
    logic [31:0] wb_data;

    always #2.5 clk = ~clk;

    ptw_top i_ptw_top (.*);

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic tick(); @(posedge clk); #1; endtask

    task automatic set_root(input logic [31:0] v);
        root_we = 1; root_wdata = v; tick(); root_we = 0;
    endtask

    // memory model: serves requests with latency lat, returns pte, records writes
    task automatic serve(input logic [31:0] exp_addr, input logic [31:0] pte, input int lat,
                         input string r);
        int guard;
        guard = 0;
        while (!mem_req && guard < 20) begin tick(); guard++; end
        chk(r, mem_addr, exp_addr);
        chk(r, {31'd0, mem_we}, 32'd0);
        for (int i = 0; i < lat; i++) begin
            tick();
            chk("R4", mem_addr, exp_addr);
        end
        mem_ack = 1; mem_rdata = pte; tick(); mem_ack = 0;
        writes_seen = 0;
        // walk until done, serving any write
        guard = 0;
        while (!fill_valid && !fault_valid && guard < 20) begin
            if (mem_req && mem_we) begin
                chk("R6", mem_addr, exp_addr);
                wb_data = mem_wdata;
                writes_seen++;
                tick(); chk("R4", mem_wdata, wb_data);
                mem_ack = 1; tick(); mem_ack = 0;
            end else tick();
            guard++;
        end
    endtask

    task automatic start_miss(input logic [19:0] vpn, input logic wr);
        miss_valid = 1; miss_vpn = vpn; miss_write = wr; tick(); miss_valid = 0;
        chk("R2", {31'd0, busy}, 32'd1);
    endtask

    task automatic t_reset();
        chk("R1", {28'd0, busy, mem_req, fill_valid, fault_valid}, 32'd0);
    endtask

    task automatic t_read_clean();
        logic [31:0] pte;
        pte = {20'hABCDE, 6'd0, 3'b101, 3'b100};
        start_miss(20'h00010, 0);
        serve(32'h0001_0040, pte, 2, "R3");
        chk("R6", writes_seen, 1);
        chk("R6", wb_data, pte | 32'h2);
        chk("R8", {31'd0, fill_valid}, 1);
        chk("R8", {12'd0, fill_pfn}, 32'hABCDE);
        chk("R8", {29'd0, fill_perm}, 32'b101);
        chk("R8", {12'd0, fill_vpn}, 32'h10);
        chk("R8", {31'd0, fill_dirty}, 0);
        tick(); chk("R2", {31'd0, busy}, 0);
    endtask

    task automatic t_write_set();
        logic [31:0] pte;
        pte = {20'h12345, 6'd0, 3'b110, 3'b110};
        start_miss(20'h00003, 1);
        serve(32'h0001_000C, pte, 0, "R3");
        chk("R6", writes_seen, 1);
        chk("R6", wb_data, pte | 32'h1);
        chk("R8", {31'd0, fill_dirty}, 1);
        tick();
    endtask

    task automatic t_no_wb();
        start_miss(20'h00004, 1);
        serve(32'h0001_0010, {20'h55555, 6'd0, 3'b111, 3'b111}, 1, "R3");
        chk("R7", writes_seen, 0);
        chk("R7", {31'd0, fill_valid}, 1);
        tick();
        start_miss(20'h00005, 0);
        serve(32'h0001_0014, {20'h0F0F0, 6'd0, 3'b001, 3'b110}, 0, "R3");
        chk("R7", writes_seen, 0);
        chk("R8", {12'd0, fill_pfn}, 32'h0F0F0);
        tick();
    endtask

    task automatic t_fault();
        start_miss(20'hFFFFF, 1);
        serve(32'h0001_0000 + 32'h3FFFFC, {20'h11111, 12'h003}, 3, "R3");
        chk("R5", writes_seen, 0);
        chk("R5", {30'd0, fill_valid, fault_valid}, 32'b01);
        chk("R5", {12'd0, fault_vpn}, 32'hFFFFF);
        tick(); chk("R5", {31'd0, fault_valid}, 0);
    endtask

    task automatic t_busy_ignore();
        start_miss(20'h00002, 0);
        miss_valid = 1; miss_vpn = 20'h00077;
        root_we = 1; root_wdata = 32'h9000_0000;
        tick(); tick();
        miss_valid = 0; root_we = 0;
        serve(32'h0001_0008, {20'h22222, 12'h007}, 1, "R2");
        chk("R2", {12'd0, fill_vpn}, 32'h2);
        tick();
        chk("R2", {31'd0, busy}, 0);
        tick(); tick();
        chk("R2", {31'd0, mem_req}, 0);
        // root unchanged: next read address uses old root
        start_miss(20'h00001, 0);
        serve(32'h0001_0004, {20'h33333, 12'h006}, 0, "R9");
        tick();
        set_root(32'h0020_0000);
        start_miss(20'h00001, 0);
        serve(32'h0020_0004, {20'h33333, 12'h006}, 0, "R9");
        tick();
    endtask

    initial begin
        fork
            begin
                repeat (3) tick();
                rst_n = 1;
                t_reset();
                set_root(32'h0001_0000);
                t_read_clean();
                t_write_set();
                t_no_wb();
                t_fault();
                t_busy_ignore();
            end
            begin
                repeat (5000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule